// File: doc/BRIEF.md
# Merging Store Buffer

This block stands between a processor core and its external bus and carries every memory write. No store reaches the bus by any other route. Stores are held in two first-in first-out queues: one holds address entries and one holds data words. Each address entry records the access kind and a word length. A multi-word store therefore takes a single address entry for all its words, which saves address slots compared with one address per word.

The core hands over one beat per cycle. The first beat of a store (the header) carries the address, the kind and, for multi-word stores, the word count, together with the first data word. The remaining words of a multi-word store follow on the next beats. The bus side drains one entry at a time. First there is an address phase, which presents the address, kind and length. Then there is a data phase, which presents the words in order and flags the last one. The address entry is released only when its last word has been taken. A drain-request output and an empty flag let the bus agent start draining, and let a barrier wait until every write has left.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the buffer is empty: `bufEmpty`=1, `busReq`=0, `busAddrValid`=0, `busDataValid`=0, and `wrReady`=1.
- R2: Address entries leave in the order they arrived, and data words leave in the order they arrived, across stores of mixed kinds.
- R3: A single store takes exactly one data word. `wrKind` encodes it as 00 byte, 01 halfword or 10 word. It drains with `busLen`=1, the same kind code, its address and its data word, with `busDataLast`=1 on that word.
- R4: A multi-word store uses `wrKind`=11 with `wrCount`=N, where N is 1 to 8. It takes one address entry and N data words. It drains with `busLen`=N and N words in order, and `busDataLast` is set only on the Nth word.
- R5: A header beat is refused (`wrReady`=0) when all 4 address entries are in use, or when fewer free data slots than the store's length remain out of 8.
- R6: An entry's address phase (`busAddrValid`) is not offered until all of its words are in the buffer. Address and data phases never overlap.
- R7: While the bus holds ready low, a valid address or data word stays offered and unchanged. The next entry's address is not offered before the current entry's last word is accepted.
- R8: `busReq` is 1 and `bufEmpty` is 0 exactly while at least one address entry is held. After everything drains, `bufEmpty` returns to 1.
- R9: Once a multi-word header is accepted, the beats that follow it are accepted every cycle (`wrReady`=1), because space was reserved for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Core offers a store beat |
| wrReady | output | 1 | Beat is accepted this cycle |
| wrAddr | input | ADDR_W | Store address (header beat) |
| wrKind | input | 2 | 00 byte, 01 half, 10 word, 11 multi (header beat) |
| wrCount | input | clog2(MAX_BURST+1) | Word count for multi stores (header beat) |
| wrData | input | DATA_W | Data word of this beat |
| busReq | output | 1 | Drain request, high while non-empty |
| bufEmpty | output | 1 | No write is pending |
| busAddrValid | output | 1 | Address phase of the head entry offered |
| busAddrReady | input | 1 | Bus takes the address phase |
| busAddr | output | ADDR_W | Head entry address |
| busKind | output | 2 | Head entry kind code |
| busLen | output | clog2(MAX_BURST+1) | Head entry word count |
| busDataValid | output | 1 | Data word offered |
| busDataReady | input | 1 | Bus takes the data word |
| busData | output | DATA_W | Head data word |
| busDataLast | output | 1 | Offered word is the entry's last |

## Verification
The assertions watch properties that must hold on every cycle. The queue counts never pass their depths. The drain request tracks occupancy. Offered address and data values hold steady under backpressure. The two drain phases never overlap, and an address is never offered before its words are present. The bench scenarios show the behaviour the assertions cannot see: the order in which stores come out, the lengths and last-word flags of mixed single and multi-word stores, the refusal of a header when either queue lacks room, and whether the words of a burst are accepted every cycle.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [1:0] {
    KIND_BYTE  = 2'b00,
    KIND_HALF  = 2'b01,
    KIND_WORD  = 2'b10,
    KIND_MULTI = 2'b11
  } kind_e;

  typedef enum logic {
    DR_ADDR = 1'b0,
    DR_DATA = 1'b1
  } drain_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pushAddr;
    logic pushData;
    logic popAddr;
    logic popData;
  } strobe_t;

endpackage

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_DEPTH = 4,
  parameter int DATA_DEPTH = 8,
  parameter int LEN_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inKind,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [1:0]        headKind,
  output logic [LEN_W-1:0]  headLen,
  output logic [DATA_W-1:0] headData
);

  localparam int AP_W = (ADDR_DEPTH > 1) ? $clog2(ADDR_DEPTH) : 1;
  localparam int DP_W = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;
  localparam logic [AP_W-1:0] A_LAST = AP_W'(ADDR_DEPTH - 1);
  localparam logic [DP_W-1:0] D_LAST = DP_W'(DATA_DEPTH - 1);

  logic [ADDR_W-1:0] addrMem [ADDR_DEPTH];
  logic [1:0]        kindMem [ADDR_DEPTH];
  logic [LEN_W-1:0]  lenMem  [ADDR_DEPTH];
  logic [DATA_W-1:0] dataMem [DATA_DEPTH];

  logic [AP_W-1:0] aWr, aRd;
  logic [DP_W-1:0] dWr, dRd;

  // pointers wrap at the depth, which need not be a power of two
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aWr <= '0;
      aRd <= '0;
      dWr <= '0;
      dRd <= '0;
    end else begin
      if (str.pushAddr) aWr <= (aWr == A_LAST) ? '0 : aWr + 1'b1;
      if (str.popAddr)  aRd <= (aRd == A_LAST) ? '0 : aRd + 1'b1;
      if (str.pushData) dWr <= (dWr == D_LAST) ? '0 : dWr + 1'b1;
      if (str.popData)  dRd <= (dRd == D_LAST) ? '0 : dRd + 1'b1;
    end
  end

  // one write-enabled slot per address entry
  for (genvar i = 0; i < ADDR_DEPTH; i++) begin : g_addrSlot
    always_ff @(posedge clk) begin
      if (str.pushAddr && aWr == AP_W'(i)) begin
        addrMem[i] <= inAddr;
        kindMem[i] <= inKind;
        lenMem[i]  <= inLen;
      end
    end
  end

  // one write-enabled slot per data word
  for (genvar j = 0; j < DATA_DEPTH; j++) begin : g_dataSlot
    always_ff @(posedge clk) begin
      if (str.pushData && dWr == DP_W'(j)) dataMem[j] <= inData;
    end
  end

  assign headAddr = addrMem[aRd];
  assign headKind = kindMem[aRd];
  assign headLen  = lenMem[aRd];
  assign headData = dataMem[dRd];

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int ADDR_DEPTH = 4,
  parameter int DATA_DEPTH = 8,
  parameter int MAX_BURST  = 8,
  parameter int LEN_W      = 4,
  parameter int ACNT_W     = 3,
  parameter int DCNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [1:0]        wrKind,
  input  logic [LEN_W-1:0]  wrCount,
  output logic              wrReady,
  output logic [LEN_W-1:0]  inLen,
  input  logic [LEN_W-1:0]  headLen,
  input  logic              busAddrReady,
  input  logic              busDataReady,
  output logic              busAddrValid,
  output logic              busDataValid,
  output logic              busDataLast,
  output strobe_t           str,
  output logic [ACNT_W-1:0] addrCount,
  output logic [DCNT_W-1:0] dataCount,
  output logic              inBurst
);

  logic [LEN_W-1:0] beatsLeft;
  logic [LEN_W-1:0] wordsLeft;
  drain_e           phase;
  logic             headerOk;
  logic             accept;

  // length requested by a header beat
  always_comb begin
    inLen = (wrKind == KIND_MULTI) ? wrCount : LEN_W'(1);
  end

  assign inBurst = (beatsLeft != '0);

  // a header needs a free address slot and room for all of its words
  always_comb begin
    headerOk = (int'(addrCount) < ADDR_DEPTH) &&
               ((int'(dataCount) + int'(inLen)) <= DATA_DEPTH) &&
               (int'(inLen) <= MAX_BURST);
  end

  assign wrReady = inBurst || headerOk;
  assign accept  = wrValid && wrReady;

  // drain side: address phase waits until the head entry is complete
  always_comb begin
    busAddrValid = (phase == DR_ADDR) && (addrCount != '0) &&
                   (int'(dataCount) >= int'(headLen));
    busDataValid = (phase == DR_DATA);
    busDataLast  = busDataValid && (wordsLeft == LEN_W'(1));
  end

  always_comb begin
    str.pushAddr = accept && !inBurst;
    str.pushData = accept;
    str.popData  = busDataValid && busDataReady;
    str.popAddr  = busDataValid && busDataReady && (wordsLeft == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCount <= '0;
      dataCount <= '0;
    end else begin
      addrCount <= addrCount + ACNT_W'(str.pushAddr) - ACNT_W'(str.popAddr);
      dataCount <= dataCount + DCNT_W'(str.pushData) - DCNT_W'(str.popData);
    end
  end

  // beats still owed by the core for the current multi-word store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatsLeft <= '0;
    end else if (accept) begin
      if (!inBurst) beatsLeft <= inLen - LEN_W'(1);
      else          beatsLeft <= beatsLeft - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= DR_ADDR;
      wordsLeft <= '0;
    end else begin
      case (phase)
        DR_ADDR: begin
          if (busAddrValid && busAddrReady) begin
            phase     <= DR_DATA;
            wordsLeft <= headLen;
          end
        end
        DR_DATA: begin
          if (str.popData) begin
            wordsLeft <= wordsLeft - LEN_W'(1);
            if (str.popAddr) phase <= DR_ADDR;
          end
        end
        default: phase <= DR_ADDR;
      endcase
    end
  end

endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
  import smb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_DEPTH = 4,
  parameter int DATA_DEPTH = 8,
  parameter int MAX_BURST  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrValid,
  output logic                             wrReady,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [1:0]                       wrKind,
  input  logic [$clog2(MAX_BURST+1)-1:0]   wrCount,
  input  logic [DATA_W-1:0]                wrData,
  output logic                             busReq,
  output logic                             bufEmpty,
  output logic                             busAddrValid,
  input  logic                             busAddrReady,
  output logic [ADDR_W-1:0]                busAddr,
  output logic [1:0]                       busKind,
  output logic [$clog2(MAX_BURST+1)-1:0]   busLen,
  output logic                             busDataValid,
  input  logic                             busDataReady,
  output logic [DATA_W-1:0]                busData,
  output logic                             busDataLast
);

  localparam int LEN_W  = $clog2(MAX_BURST + 1);
  localparam int ACNT_W = $clog2(ADDR_DEPTH + 1);
  localparam int DCNT_W = $clog2(DATA_DEPTH + 1);

  strobe_t           str;
  logic [LEN_W-1:0]  inLen;
  logic [LEN_W-1:0]  headLen;
  logic [ACNT_W-1:0] addrCount;
  logic [DCNT_W-1:0] dataCount;
  logic              inBurst;

  smb_ctrl #(
    .ADDR_DEPTH(ADDR_DEPTH),
    .DATA_DEPTH(DATA_DEPTH),
    .MAX_BURST (MAX_BURST),
    .LEN_W     (LEN_W),
    .ACNT_W    (ACNT_W),
    .DCNT_W    (DCNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .wrKind      (wrKind),
    .wrCount     (wrCount),
    .wrReady     (wrReady),
    .inLen       (inLen),
    .headLen     (headLen),
    .busAddrReady(busAddrReady),
    .busDataReady(busDataReady),
    .busAddrValid(busAddrValid),
    .busDataValid(busDataValid),
    .busDataLast (busDataLast),
    .str         (str),
    .addrCount   (addrCount),
    .dataCount   (dataCount),
    .inBurst     (inBurst)
  );

  smb_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ADDR_DEPTH(ADDR_DEPTH),
    .DATA_DEPTH(DATA_DEPTH),
    .LEN_W     (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .inAddr  (wrAddr),
    .inKind  (wrKind),
    .inLen   (inLen),
    .inData  (wrData),
    .headAddr(busAddr),
    .headKind(busKind),
    .headLen (headLen),
    .headData(busData)
  );

  assign busLen   = headLen;
  assign bufEmpty = (addrCount == '0);
  assign busReq   = !bufEmpty;

endmodule

// File: rtl/smb_checker.sv
module smb_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_DEPTH = 4,
  parameter int DATA_DEPTH = 8,
  parameter int MAX_BURST  = 8
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                wrReady,
  input logic                                busReq,
  input logic                                bufEmpty,
  input logic                                busAddrValid,
  input logic                                busAddrReady,
  input logic [ADDR_W-1:0]                   busAddr,
  input logic [$clog2(MAX_BURST+1)-1:0]      busLen,
  input logic                                busDataValid,
  input logic                                busDataReady,
  input logic [DATA_W-1:0]                   busData,
  input logic [$clog2(ADDR_DEPTH+1)-1:0]     addrCount,
  input logic [$clog2(DATA_DEPTH+1)-1:0]     dataCount,
  input logic                                inBurst
);

  // R5: occupancy never exceeds the queue depths
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addrCount) <= ADDR_DEPTH) && (int'(dataCount) <= DATA_DEPTH));

  // R5: a full address queue refuses new headers
  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addrCount) == ADDR_DEPTH && !inBurst) |-> !wrReady);

  // R8: drain request follows occupancy
  p_req_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReq == (addrCount != '0) && bufEmpty == !busReq);

  // R8: nothing is offered on the bus when empty
  p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> !busAddrValid && !busDataValid);

  // R6: phases are exclusive
  p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(busAddrValid && busDataValid));

  // R6: the entry's words are all present when its address is offered
  p_words_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid |-> int'(dataCount) >= int'(busLen));

  // R4: offered length is in range
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid |-> (busLen != '0) && (int'(busLen) <= MAX_BURST));

  // R7: address held steady under backpressure
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid && !busAddrReady |=> busAddrValid && $stable(busAddr) && $stable(busLen));

  // R7: data word held steady under backpressure
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    busDataValid && !busDataReady |=> busDataValid && $stable(busData));

endmodule

bind store_merge_buffer smb_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .ADDR_DEPTH(ADDR_DEPTH),
  .DATA_DEPTH(DATA_DEPTH),
  .MAX_BURST (MAX_BURST)
) u_chk (.*);

// File: tb/sim_store_merge_buffer.sv
`timescale 1ns/1ps
module sim_store_merge_buffer;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [31:0] wrAddr = '0;
  logic [1:0]  wrKind = '0;
  logic [3:0]  wrCount = '0;
  logic [31:0] wrData = '0;
  logic        busReq, bufEmpty;
  logic        busAddrValid;
  logic        busAddrReady = 1'b0;
  logic [31:0] busAddr;
  logic [1:0]  busKind;
  logic [3:0]  busLen;
  logic        busDataValid;
  logic        busDataReady = 1'b0;
  logic [31:0] busData;
  logic        busDataLast;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  store_merge_buffer u0 (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrKind(wrKind),
    .wrCount(wrCount), .wrData(wrData),
    .busReq(busReq), .bufEmpty(bufEmpty),
    .busAddrValid(busAddrValid), .busAddrReady(busAddrReady), .busAddr(busAddr),
    .busKind(busKind), .busLen(busLen),
    .busDataValid(busDataValid), .busDataReady(busDataReady), .busData(busData),
    .busDataLast(busDataLast)
  );

  // kind, count, address, first data word
  localparam logic [69:0] VEC [4] = '{
    {2'd0, 4'd1, 32'h1000_0001, 32'h0000_00AA},
    {2'd1, 4'd1, 32'h1000_0002, 32'h0000_BBBB},
    {2'd3, 4'd3, 32'h2000_0000, 32'hC000_0000},
    {2'd2, 4'd1, 32'h3000_0004, 32'hDEAD_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lenOf(input logic [1:0] k, input logic [3:0] c);
    return (k == 2'd3) ? c : 4'd1;
  endfunction

  // push one store; burst beats after the header must be taken at once (R9)
  task automatic pushStore(input logic [1:0] k, input logic [3:0] c,
                           input logic [31:0] a, input logic [31:0] base);
    int n = int'(lenOf(k, c));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrValid = 1'b1; wrAddr = a; wrKind = k; wrCount = c; wrData = base + i;
      #1;
      if (i > 0) chk("R9 burst beat ready", 64'(wrReady), 64'd1);
      while (!wrReady) begin
        @(negedge clk); #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // drain one entry and compare every field; optional stall on first word
  task automatic drainOne(input string req, input logic [1:0] k, input logic [3:0] c,
                          input logic [31:0] a, input logic [31:0] base, input int stall);
    int n = int'(lenOf(k, c));
    @(negedge clk);
    busAddrReady = 1'b1;
    #1;
    chk({req, " addr valid"}, 64'(busAddrValid), 64'd1);
    chk({req, " addr"}, 64'(busAddr), 64'(a));
    chk({req, " kind"}, 64'(busKind), 64'(k));
    chk({req, " len"}, 64'(busLen), 64'(n));
    @(posedge clk);
    @(negedge clk);
    busAddrReady = 1'b0;
    for (int s = 0; s < stall; s++) begin
      #1;
      chk("R7 data held valid", 64'(busDataValid), 64'd1);
      chk("R7 data held value", 64'(busData), 64'(base));
      chk("R7 no next address", 64'(busAddrValid), 64'd0);
      @(posedge clk);
      @(negedge clk);
    end
    for (int w = 0; w < n; w++) begin
      busDataReady = 1'b1;
      #1;
      chk({req, " data valid"}, 64'(busDataValid), 64'd1);
      chk({req, " data"}, 64'(busData), 64'(base + w));
      chk({req, " last"}, 64'(busDataLast), 64'(w == n - 1));
      @(posedge clk);
      @(negedge clk);
    end
    busDataReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 empty", 64'(bufEmpty), 64'd1);
    chk("R1 req", 64'(busReq), 64'd0);
    chk("R1 addr valid", 64'(busAddrValid), 64'd0);
    chk("R1 data valid", 64'(busDataValid), 64'd0);
    chk("R1 ready", 64'(wrReady), 64'd1);

    // table walk: mixed stores, then drain in order (R2, R3, R4)
    for (int i = 0; i < 4; i++)
      pushStore(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);
    #1;
    chk("R8 req after fill", 64'(busReq), 64'd1);
    for (int i = 0; i < 4; i++)
      drainOne((VEC[i][69:68] == 2'd3) ? "R4 R2 multi" : "R3 R2 single",
               VEC[i][69:68], VEC[i][67:64], VEC[i][63:32], VEC[i][31:0], 0);
    #1;
    chk("R8 empty after drain", 64'(bufEmpty), 64'd1);
    chk("R8 req after drain", 64'(busReq), 64'd0);

    // address queue full (R5)
    for (int i = 0; i < 4; i++) pushStore(2'd2, 4'd0, 32'h4000_0000 + 4 * i, 32'h100 + i);
    @(negedge clk);
    wrValid = 1'b1; wrKind = 2'd2; wrAddr = 32'h4000_0010; wrData = 32'h104;
    #1;
    chk("R5 addr full stall", 64'(wrReady), 64'd0);
    @(negedge clk);
    wrValid = 1'b0;
    drainOne("R2 after full", 2'd2, 4'd0, 32'h4000_0000, 32'h100, 0);
    pushStore(2'd2, 4'd0, 32'h4000_0010, 32'h104);
    for (int i = 1; i < 5; i++)
      drainOne("R2 refill order", 2'd2, 4'd0, 32'h4000_0000 + 4 * i, 32'h100 + i, 0);

    // data queue full with one address entry (R5), then backpressure (R7)
    pushStore(2'd3, 4'd8, 32'h5000_0000, 32'hA0);
    @(negedge clk);
    wrValid = 1'b1; wrKind = 2'd0; wrAddr = 32'h5000_0100; wrData = 32'h1;
    #1;
    chk("R5 data full stall", 64'(wrReady), 64'd0);
    @(negedge clk);
    wrValid = 1'b0;
    drainOne("R4 eight-word", 2'd3, 4'd8, 32'h5000_0000, 32'hA0, 3);

    // incomplete burst must not be offered (R6)
    @(negedge clk);
    busAddrReady = 1'b1;
    wrValid = 1'b1; wrKind = 2'd3; wrCount = 4'd4; wrAddr = 32'h6000_0000; wrData = 32'h60;
    @(posedge clk);
    @(negedge clk);
    wrData = 32'h61;
    #1;
    chk("R6 partial burst hidden", 64'(busAddrValid), 64'd0);
    chk("R8 req during burst", 64'(busReq), 64'd1);
    @(posedge clk);
    @(negedge clk);
    wrData = 32'h62;
    @(posedge clk);
    @(negedge clk);
    wrData = 32'h63;
    #1;
    chk("R6 still hidden on last beat", 64'(busAddrValid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0;
    busAddrReady = 1'b0;
    #1;
    chk("R6 complete burst offered", 64'(busAddrValid), 64'd1);
    drainOne("R6 R4 four-word", 2'd3, 4'd4, 32'h6000_0000, 32'h60, 0);
    #1;
    chk("R8 final empty", 64'(bufEmpty), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule